// File: doc/BRIEF.md
# External Memory Strobe Sequencer

This block turns single-word requests from a processor core into read and write cycles on an asynchronous external memory bus. It drives a 14-bit address, three active-low space selects (program, data and boot), active-low read and write strobes, and a data bus that is split into an output value, an output enable and an input value. The pad ring joins these three into the bidirectional pins.

The sequencer runs on a clock four times faster than the processor cycle. Each fast clock is one quarter of a processor cycle. This lets every bus edge fall on a quarter-cycle boundary. A free-running quarter counter marks the processor cycle: quarter 0 is the rising edge of the processor clock.

A request is accepted only in the last quarter of a processor cycle. Address and select then appear in quarter 0 of the next cycle, and the strobe falls in quarter 1. A wait-state count given with the request stretches the strobe by whole processor cycles. The setup and hold quarters do not change. The core holds its request and fields stable until it sees the one-clock acknowledge. It drops or replaces the request on the clock after that.

Top module: `ext_mem_strobe_seq`

## Requirements
- R1: While reset is high and on the first clock after it, both strobes and all three selects are high, the data output enable and the acknowledge are low, and the captured read data is zero.
- R2: The space code picks the select line that goes low: 0 drives bit 0 (program), 1 drives bit 1 (data), and 2 or 3 drives bit 2 (boot). At most one select is low at any time, and all are high when no access is running.
- R3: The address and the select become valid exactly one clock before the strobe falls. The strobe always falls in quarter 1 of the processor cycle.
- R4: The strobe stays low for 2 + 4×W clocks, where W is the wait-state count.
- R5: The address and the select stay unchanged for exactly one clock after the strobe rises. The select then returns high, and the address keeps its last value.
- R6: On a write, the data output enable rises in the same clock as the write strobe falls and drops one clock after the write strobe rises. While it is high, the data output carries the request's write data. The enable is never high during a read.
- R7: A read captures the data input at the clock edge where the read strobe rises. For both reads and writes, the acknowledge is high for exactly that one hold clock.
- R8: The 3-bit wait-state count is sampled only when the request is accepted. Changing it during the access has no effect on the strobe length.
- R9: After a strobe rises, at least two clocks pass before any strobe falls again. A request that is held across the acknowledge produces its next strobe fall exactly six clocks after the previous rise.
- R10: A request is accepted only when no access is running and the quarter counter is 3. A request raised in any other quarter waits for the next quarter 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-cycle clock (four per processor cycle) |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Core request, held until acknowledge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_space | input | 2 | Space code: 0 program, 1 data, 2/3 boot |
| req_addr | input | 14 | Word address |
| req_wdata | input | 16 | Write data |
| req_ws | input | 3 | Wait-state count |
| ack | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Last captured read data |
| mem_addr | output | 14 | External address bus |
| mem_sel_n | output | 3 | Active-low space selects (bit 0 program, 1 data, 2 boot) |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_d_out | output | 16 | Data bus output value |
| mem_d_oe | output | 1 | Data bus output enable |
| mem_d_in | input | 16 | Data bus input value |

## Verification
An accepted request shows its address and select on the clock after the accepting edge. The strobe falls one clock later and rises 2 + 4×W clocks after that. The acknowledge and the captured read data appear in the same hold clock, and the select and the output enable clear one clock later.

The bench keeps a behavioural model that counts quarters from the accepting edge. The model updates at each rising edge using only the bench's own inputs. Every output is compared against the model at the following falling edge, so each result is checked in the exact clock it becomes due. Strobe-length and gap measurements taken at the pins back up these per-clock compares.

// File: rtl/msq_pkg.sv
package msq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_e;

  localparam int QUARTERS = 4;
  localparam int PH_W     = $clog2(QUARTERS);
endpackage

// File: rtl/msq_phase.sv
module msq_phase
  import msq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] ph,
  output logic            last_q
);
  // Free-running quarter counter; quarter 0 marks the processor clock rising edge.
  always_ff @(posedge clk) begin
    if (rst) ph <= '0;
    else     ph <= ph + 1'b1;
  end

  assign last_q = (ph == PH_W'(QUARTERS - 1));
endmodule

// File: rtl/msq_ctrl.sv
module msq_ctrl
  import msq_pkg::*;
#(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            last_q,
  input  logic            req,
  input  logic [WS_W-1:0] req_ws,
  output logic            accept,
  output logic            go_low,
  output logic            go_high,
  output logic            done
);
  localparam int CNT_W = WS_W + 2;

  seq_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [WS_W-1:0]  ws_q;

  // R10: accept only from idle and only in the last quarter of a processor cycle
  assign accept  = last_q && req && (st == ST_IDLE);
  assign go_low  = (st == ST_SETUP);
  assign go_high = (st == ST_STROBE) && (cnt == '0);
  assign done    = (st == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      ws_q <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            st   <= ST_SETUP;
            ws_q <= req_ws;   // R8: sampled once, at acceptance
          end
        end
        ST_SETUP: begin
          st  <= ST_STROBE;
          cnt <= {ws_q, 2'b01};   // 4*W + 1 -> strobe low for 4*W + 2 clocks
        end
        ST_STROBE: begin
          if (cnt == '0) st <= ST_HOLD;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10: the setup quarter always follows a last-quarter clock
  a_r10_setup_after_last: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETUP) |-> $past(last_q));

  // R4: the down-counter only counts while the strobe is active
  a_r4_count_steps: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_STROBE) && $past(st == ST_STROBE)) |-> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/msq_bus.sv
module msq_bus #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  parameter int SPACES = 3,
  parameter int SP_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              go_low,
  input  logic              go_high,
  input  logic              done,
  input  logic              req_we,
  input  logic [SP_W-1:0]   req_space,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] d_in,
  output logic [ADDR_W-1:0] addr,
  output logic [SPACES-1:0] sel_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] d_out,
  output logic              d_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              ack
);
  logic [SPACES-1:0] hit;
  logic              we_q;

  // R2: space decode; the top select also takes every code above its index
  for (genvar g = 0; g < SPACES; g++) begin : g_dec
    if (g == SPACES - 1) begin : g_top
      assign hit[g] = (req_space >= SP_W'(g));
    end else begin : g_low
      assign hit[g] = (req_space == SP_W'(g));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      sel_n <= '1;
      rd_n  <= 1'b1;
      wr_n  <= 1'b1;
      d_out <= '0;
      d_oe  <= 1'b0;
      rdata <= '0;
      ack   <= 1'b0;
      we_q  <= 1'b0;
    end else begin
      ack <= go_high;
      if (accept) begin
        addr  <= req_addr;
        sel_n <= ~hit;
        we_q  <= req_we;
        d_out <= req_wdata;
      end
      if (go_low) begin
        if (we_q) begin
          wr_n <= 1'b0;
          d_oe <= 1'b1;
        end else begin
          rd_n <= 1'b0;
        end
      end
      if (go_high) begin
        rd_n <= 1'b1;
        wr_n <= 1'b1;
        if (!we_q) rdata <= d_in;   // R7: capture at the rising read edge
      end
      if (done) begin
        sel_n <= '1;
        d_oe  <= 1'b0;
      end
    end
  end

  // R2: never more than one space select active
  a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~sel_n));

  // R6: the data bus is never driven during a read strobe
  a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
    d_oe |-> rd_n);
endmodule

// File: rtl/ext_mem_strobe_seq.sv
module ext_mem_strobe_seq
  import msq_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16,
  parameter int WS_W   = 3,
  parameter int SPACES = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req,
  input  logic                       req_we,
  input  logic [$clog2(SPACES)-1:0]  req_space,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [DATA_W-1:0]          req_wdata,
  input  logic [WS_W-1:0]            req_ws,
  output logic                       ack,
  output logic [DATA_W-1:0]          rdata,
  output logic [ADDR_W-1:0]          mem_addr,
  output logic [SPACES-1:0]          mem_sel_n,
  output logic                       mem_rd_n,
  output logic                       mem_wr_n,
  output logic [DATA_W-1:0]          mem_d_out,
  output logic                       mem_d_oe,
  input  logic [DATA_W-1:0]          mem_d_in
);
  localparam int SP_W = $clog2(SPACES);
  localparam int LC_W = WS_W + 3;

  logic [PH_W-1:0] ph;
  logic            last_q;
  logic            accept, go_low, go_high, done;

  msq_phase u_phase (
    .clk    (clk),
    .rst    (rst),
    .ph     (ph),
    .last_q (last_q)
  );

  msq_ctrl #(.WS_W(WS_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .last_q  (last_q),
    .req     (req),
    .req_ws  (req_ws),
    .accept  (accept),
    .go_low  (go_low),
    .go_high (go_high),
    .done    (done)
  );

  msq_bus #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SPACES (SPACES),
    .SP_W   (SP_W)
  ) u_bus (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .go_low    (go_low),
    .go_high   (go_high),
    .done      (done),
    .req_we    (req_we),
    .req_space (req_space),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .d_in      (mem_d_in),
    .addr      (mem_addr),
    .sel_n     (mem_sel_n),
    .rd_n      (mem_rd_n),
    .wr_n      (mem_wr_n),
    .d_out     (mem_d_out),
    .d_oe      (mem_d_oe),
    .rdata     (rdata),
    .ack       (ack)
  );

  // Pin-level window counters for the timing checks
  logic            strobe_hi;
  logic [LC_W-1:0] low_cnt;
  logic [1:0]      gap_cnt;
  logic [WS_W-1:0] ws_chk;

  assign strobe_hi = mem_rd_n && mem_wr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      gap_cnt <= 2'd3;
      ws_chk  <= '0;
    end else begin
      if (accept) ws_chk <= req_ws;
      if (strobe_hi) begin
        low_cnt <= '0;
        if (gap_cnt != 2'd3) gap_cnt <= gap_cnt + 1'b1;
      end else begin
        low_cnt <= low_cnt + 1'b1;
        gap_cnt <= '0;
      end
    end
  end

  // R2: a strobe is never active without a space select, and never both strobes
  a_r2_strobe_needs_select: assert property (@(posedge clk) disable iff (rst)
    !strobe_hi |-> (mem_sel_n != '1 && (mem_rd_n || mem_wr_n)));

  // R3: address and select settled for one clock before the strobe falls
  a_r3_setup: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_hi) |-> (mem_sel_n != '1 && $stable(mem_sel_n) && $stable(mem_addr)));

  // R3: the strobe falls in quarter 1
  a_r3_fall_phase: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_hi) |-> (ph == PH_W'(1)));

  // R4: strobe width matches the accepted wait-state count
  a_r4_width: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_hi) |-> (low_cnt == LC_W'({ws_chk, 2'b10})));

  // R5: address and select held through the clock after the strobe rises
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_hi) |-> (mem_sel_n != '1 && $stable(mem_addr) && $stable(mem_sel_n)));

  // R6: bus released before any strobe falls, write data held one clock past WR
  a_r6_release_before_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_hi) |-> !$past(mem_d_oe));
  a_r6_hold_after_wr: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr_n) |-> mem_d_oe);
  a_r6_drop_after_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_wr_n) |=> !mem_d_oe);

  // R7: acknowledge coincides with the strobe rising
  a_r7_ack_at_rise: assert property (@(posedge clk) disable iff (rst)
    ack |-> $rose(strobe_hi));

  // R9: at least two high clocks between a rise and the next fall
  a_r9_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_hi) |-> (gap_cnt >= 2'd2));
endmodule

// File: tb/ext_mem_strobe_seq_tb.sv
module ext_mem_strobe_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_we = 1'b0;
  logic [1:0]  req_space = 2'd0;
  logic [13:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [2:0]  req_ws = '0;
  logic        ack;
  logic [15:0] rdata;
  logic [13:0] mem_addr;
  logic [2:0]  mem_sel_n;
  logic        mem_rd_n, mem_wr_n, mem_d_oe;
  logic [15:0] mem_d_out;
  logic [15:0] mem_d_in = 16'h0000;

  always #2.5 clk = ~clk;

  ext_mem_strobe_seq u_dut (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_space(req_space),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ws(req_ws),
    .ack(ack), .rdata(rdata), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_d_out(mem_d_out),
    .mem_d_oe(mem_d_oe), .mem_d_in(mem_d_in)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit started = 0;
  bit finished = 0;
  int cyc = 0;

  // Behavioural reference: quarter index inside the running access
  int          m_ph, m_t, m_len;
  bit          m_busy, m_we;
  logic [1:0]  m_sp;
  logic [13:0] m_addr;
  logic [15:0] m_wd, m_rdata;

  always @(posedge clk) begin
    bit acc;
    started = 1;
    if (rst) begin
      m_ph = 0; m_t = 0; m_len = 4; m_busy = 0; m_we = 0;
      m_sp = 0; m_addr = '0; m_wd = '0; m_rdata = '0;
    end else begin
      acc = (m_ph == 3) && req && !m_busy;
      if (m_busy) begin
        if (m_t == m_len - 1) m_busy = 0;
        else m_t++;
      end
      if (acc) begin
        m_busy = 1; m_t = 0; m_we = req_we; m_sp = req_space;
        m_addr = req_addr; m_wd = req_wdata; m_len = 4 + 4 * int'(req_ws);
      end
      if (m_busy && !m_we && m_t == m_len - 1) m_rdata = mem_d_in;
      m_ph = (m_ph + 1) % 4;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Per-clock comparison, sampled at the falling edge
  int hi_streak = 0;
  int last_gap = -1;
  bit prev_low = 0;
  always @(negedge clk) begin
    bit win, lowx;
    logic [2:0] esel;
    if (started && !finished) begin
      win  = m_busy && m_t >= 1 && m_t <= m_len - 2;
      esel = 3'b111;
      if (m_busy) esel[(m_sp >= 2) ? 2 : int'(m_sp)] = 1'b0;
      chk(rst ? "R1" : "R3", "rd_n", 32'(mem_rd_n), 32'(!(win && !m_we)));
      chk(rst ? "R1" : "R4", "wr_n", 32'(mem_wr_n), 32'(!(win && m_we)));
      chk(rst ? "R1" : "R2", "sel_n", 32'(mem_sel_n), 32'(esel));
      chk(rst ? "R1" : "R6", "d_oe", 32'(mem_d_oe), 32'(m_busy && m_we && m_t >= 1));
      chk(rst ? "R1" : "R7", "ack", 32'(ack), 32'(m_busy && m_t == m_len - 1));
      chk(rst ? "R1" : "R7", "rdata", 32'(rdata), 32'(m_rdata));
      if (!rst) chk("R5", "addr", 32'(mem_addr), 32'(m_addr));
      if (!rst && m_busy && m_we && m_t >= 1) chk("R6", "d_out", 32'(mem_d_out), 32'(m_wd));
      lowx = !(mem_rd_n && mem_wr_n);
      if (lowx && !prev_low) last_gap = hi_streak;
      hi_streak = lowx ? 0 : hi_streak + 1;
      prev_low = lowx;
    end
    mem_d_in = mem_d_in * 16'd5 + 16'h1357;
  end

  task automatic summary();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      n_tests++; n_fail++;
      $display("FAIL R10 watchdog: actual %0d cycles expected completion earlier", cyc);
      summary();
    end
  end

  // Issue one access; hold the request until ack; optionally alter req_ws mid-access.
  task automatic access(input bit we, input logic [1:0] sp, input logic [13:0] a,
                        input logic [15:0] d, input logic [2:0] ws,
                        input int pre_idle, input bit alter_ws, input string wtag);
    int lows = 0;
    repeat (pre_idle) @(negedge clk);
    req = 1; req_we = we; req_space = sp; req_addr = a; req_wdata = d; req_ws = ws;
    do begin
      @(negedge clk);
      if (!(mem_rd_n && mem_wr_n)) lows++;
      if (alter_ws && lows == 1) req_ws = 3'd0;
    end while (!ack);
    req = 0;
    // R4 / R8: strobe width measured at the pins against the accepted count
    chk(wtag, "strobe width", 32'(lows), 32'(2 + 4 * int'(ws)));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: idle outputs while reset is still asserted
    chk("R1", "sel idle", 32'(mem_sel_n), 32'h7);
    rst = 0;
    @(negedge clk);
    chk("R1", "strobes after reset", 32'({mem_rd_n, mem_wr_n}), 32'h3);
    access(0, 2'd0, 14'h0123, 16'h0000, 3'd0, 1, 0, "R4");
    access(1, 2'd1, 14'h3ABC, 16'hA5A5, 3'd0, 2, 0, "R4");
    access(0, 2'd2, 14'h1FFF, 16'h0000, 3'd3, 3, 0, "R4");
    access(1, 2'd3, 14'h2468, 16'h5A0F, 3'd7, 1, 1, "R8");
    access(0, 2'd1, 14'h0001, 16'h0000, 3'd1, 5, 0, "R10");
    // R9: held request across the ack gives the tightest spacing
    access(1, 2'd0, 14'h0400, 16'h1234, 3'd2, 0, 0, "R4");
    access(1, 2'd0, 14'h0401, 16'h4321, 3'd2, 0, 0, "R4");
    chk("R9", "rise-to-fall gap", 32'(last_gap), 32'd6);
    access(0, 2'd0, 14'h0402, 16'h0000, 3'd0, 0, 0, "R4");
    chk("R9", "read after write gap", 32'(last_gap), 32'd6);
    repeat (12) @(negedge clk);
    chk("R2", "selects idle", 32'(mem_sel_n), 32'h7);
    summary();
  end
endmodule